// File: doc/BRIEF.md
# Multi-Pulse Square-Wave Gate Generator

This block drives the 48 gate signals of a series converter made of eight three-phase six-pulse bridges, each switched once per fundamental cycle. A free-running phase accumulator sets the line frequency. Every bridge leg compares its own shifted phase against half scale and produces a square wave, so each switch closes once and opens once per cycle. The phase of a leg is the sum of four terms: a three-phase term, a delta/wye bridge term, a term for its twelve-pulse unit, and a phase command for its converter group. Adding the staggered square waves at the transformers gives a near 48-pulse voltage.

Two phase commands, one for group A and one for group B, arrive with a valid strobe. They are held and take effect only at the next wrap of the accumulator. A small guard keeps both switches of a leg off for a set number of clocks after every level change.

Leg numbering: leg `l` (0..23) belongs to bridge `l/3` and phase `l%3`. It belongs to unit `l/6` and to bridge kind `(l/3)%2` (0 = wye, 1 = delta). It belongs to group `l/12` (0 = A, 1 = B).

Top module: `mp_gate_gen`

## Requirements
- R1: Reset clears the accumulator to zero. All 48 gates stay low from reset until the accumulator first wraps back to zero.
- R2: Every DIV clocks, the accumulator advances by STEP modulo 2^PHW. With the default PHW of 16 a full turn is 65536 counts, so the output period is DIV·2^PHW/STEP clocks.
- R3: Each leg computes a phase sum, modulo 2^PHW: the accumulator value of the previous clock, plus the leg offset, plus its group's active command. The upper switch of the leg is ordered on while this sum is below 2^(PHW-1). The lower switch is ordered on otherwise.
- R4: The phase term is 0 counts for phase 0, −21845 counts (−120°) for phase 1 and +21845 counts for phase 2. On `gate[6b+n-1]` for bridge b, the upper/lower pairs are gate numbers 1/4 (phase 0), 3/6 (phase 1) and 5/2 (phase 2).
- R5: The bridge term is 0 for the wye bridge and −5461 counts (−30°) for the delta bridge of each unit.
- R6: The unit term is +1365, 0, −1365 and −2731 counts (+7.5°, 0°, −7.5°, −15°) for units 0 to 3. Units 0–1 form group A and use `cmd_a`. Units 2–3 form group B and use `cmd_b`.
- R7: A command is captured only in a clock where `cmd_vld` is high, and the last capture wins. A captured command becomes active at the next accumulator wrap. Command inputs that change while `cmd_vld` is low have no effect.
- R8: After any change in a leg's ordered level, both gates of that leg stay low for GUARD clocks. The two gates of a pair are never high together.
- R9: While the commands stay constant, each gate rises exactly once per output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_a | input | PHW | Group A phase command, 2^PHW counts per turn |
| cmd_b | input | PHW | Group B phase command |
| cmd_vld | input | 1 | Capture strobe for both commands |
| gate | output | 48 | Gate drives, six per bridge, index 6·bridge + gate number − 1 |

## Verification
The assertions assume that STEP divides 2^PHW, so that the accumulator passes through zero exactly once per turn and the first wrap falls at a fixed clock count. They also assume a GUARD of at least one. The stimulus keeps STEP a power of two and GUARD at three. It changes the commands only well inside a period, either under the strobe or with the strobe low. Exact switching positions are checked only in periods whose whole history used one command pair, and the periods right after a command change are checked only for pair exclusion.

// File: rtl/mp_gate_gen.sv
module mp_gate_gen #(
  parameter int PHW   = 16,
  parameter int STEP  = 1,
  parameter int DIV   = 61,
  parameter int GUARD = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PHW-1:0] cmd_a,
  input  logic [PHW-1:0] cmd_b,
  input  logic           cmd_vld,
  output logic [47:0]    gate
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int GW = (GUARD > 0) ? $clog2(GUARD + 1) : 1;

  function automatic logic [PHW-1:0] to_cnt(input int d10);
    longint mag;
    logic [PHW-1:0] r;
    mag = (d10 < 0) ? -longint'(d10) : longint'(d10);
    mag = (mag * (longint'(1) << PHW) + 1800) / 3600;
    r = mag[PHW-1:0];
    return (d10 < 0) ? ({PHW{1'b0}} - r) : r;
  endfunction

  logic [DW-1:0]  div_cnt;
  logic [PHW-1:0] acc, pend_a, pend_b, act_a, act_b;
  logic           armed;
  logic [PHW:0]   nxt;
  logic           tick, wrap;

  assign tick = (div_cnt == DW'(DIV - 1));
  assign nxt  = {1'b0, acc} + (PHW+1)'(STEP);
  assign wrap = tick & nxt[PHW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      acc     <= '0;
      pend_a  <= '0;
      pend_b  <= '0;
      act_a   <= '0;
      act_b   <= '0;
      armed   <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) acc <= nxt[PHW-1:0];
      if (cmd_vld) begin
        pend_a <= cmd_a;
        pend_b <= cmd_b;
      end
      if (wrap) begin
        act_a <= pend_a;
        act_b <= pend_b;
        armed <= 1'b1;
      end
    end
  end

  for (genvar l = 0; l < 24; l++) begin : g_leg
    localparam int PH   = l % 3;
    localparam int BR   = (l / 3) % 2;
    localparam int UNIT = l / 6;
    localparam int GRP  = l / 12;
    localparam int BI   = l / 3;
    localparam int UPB  = BI * 6 + 2 * PH;
    localparam int DNB  = BI * 6 + ((PH == 0) ? 3 : (PH == 1) ? 5 : 1);
    localparam logic [PHW-1:0] OFF =
        to_cnt((PH == 0) ? 0 : (PH == 1) ? -1200 : 1200) +
        to_cnt(BR ? -300 : 0) +
        to_cnt(75 - 75 * UNIT);

    logic [PHW-1:0] ph;
    logic           lvl, lvl_q;
    logic [GW-1:0]  gcnt;

    assign ph  = acc + OFF + ((GRP == 0) ? act_a : act_b);
    assign lvl = ~ph[PHW-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_q <= 1'b0;
        gcnt  <= '0;
      end else begin
        lvl_q <= lvl;
        if (lvl != lvl_q)   gcnt <= GW'(GUARD);
        else if (gcnt != 0) gcnt <= gcnt - 1'b1;
      end
    end

    assign gate[UPB] = armed & (gcnt == 0) & lvl_q;
    assign gate[DNB] = armed & (gcnt == 0) & ~lvl_q;
  end
endmodule

// File: rtl/mp_gate_chk.sv
module mp_gate_chk #(
  parameter int PHW   = 16,
  parameter int STEP  = 1,
  parameter int DIV   = 61,
  parameter int GUARD = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [47:0]    gate,
  input logic [PHW-1:0] acc,
  input logic           tick,
  input logic           wrap,
  input logic [PHW-1:0] act_a,
  input logic [PHW-1:0] act_b
);
  localparam int PERIOD = DIV * (1 << PHW) / STEP;

  int since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= 0;
    else if (since < PERIOD) since <= since + 1;
  end

  // R1
  quiet_before_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since < PERIOD) |-> (gate == '0));

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (acc == $past(acc) + PHW'(STEP)));

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc));

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_a) && $stable(act_b)));

  for (genvar p = 0; p < 24; p++) begin : g_pair
    localparam int UP = (p / 3) * 6 + 2 * (p % 3);
    localparam int DN = (p / 3) * 6 + ((p % 3 == 0) ? 3 : (p % 3 == 1) ? 5 : 1);

    // R8
    pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[UP] && gate[DN]));

    // R8
    guard_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[UP]) |-> $past(!gate[DN]));

    // R8
    guard_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[DN]) |-> $past(!gate[UP]));
  end
endmodule

bind mp_gate_gen mp_gate_chk #(.PHW(PHW), .STEP(STEP), .DIV(DIV), .GUARD(GUARD)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .acc(acc), .tick(tick),
  .wrap(wrap), .act_a(act_a), .act_b(act_b)
);

// File: tb/mp_gate_gen_bench.sv
module mp_gate_gen_bench;
  localparam int PHW = 16, STEP = 8, DIV = 1, GUARD = 3;
  localparam int M = 1 << PHW, H = M / 2, P = DIV * M / STEP;

  logic clk = 1'b0, rst_n = 1'b0, cmd_vld = 1'b0;
  logic [PHW-1:0] cmd_a = '0, cmd_b = '0;
  logic [47:0] gate;

  mp_gate_gen #(.PHW(PHW), .STEP(STEP), .DIV(DIV), .GUARD(GUARD)) u_mp_gate_gen (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_vld(cmd_vld), .gate(gate)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0, e = 0;
  bit finished = 0;
  always @(posedge clk) if (rst_n) e <= e + 1;

  typedef struct { int g; int pos; int win; } exp_t;
  exp_t q[$];

  // R4 R5 R6: offsets in counts
  function automatic int leg_off(int leg);
    int ph_c[3] = '{0, -21845, 21845};
    int br_c[2] = '{0, -5461};
    int un_c[4] = '{1365, 0, -1365, -2731};
    return ph_c[leg % 3] + br_c[(leg / 3) % 2] + un_c[leg / 6];
  endfunction

  function automatic int exp_rise(int g, int ca, int cb);
    int n = g % 6, phs, leg, o, r;
    bit up;
    case (n)
      0: begin phs = 0; up = 1; end
      1: begin phs = 2; up = 0; end
      2: begin phs = 1; up = 1; end
      3: begin phs = 0; up = 0; end
      4: begin phs = 2; up = 1; end
      default: begin phs = 1; up = 0; end
    endcase
    leg = (g / 6) * 3 + phs;
    o = leg_off(leg) + ((leg / 12 == 0) ? ca : cb);
    r = up ? ((-o) % M + M) % M : ((H - o) % M + M) % M;
    return ((r + STEP - 1) / STEP + 1 + GUARD) % P;
  endfunction

  task automatic push_period(int win, int ca, int cb);
    for (int g = 0; g < 48; g++) q.push_back('{g, exp_rise(g, ca, cb), win});
  endtask

  task automatic strobe(int ca, int cb);
    @(negedge clk);
    cmd_a = PHW'(ca); cmd_b = PHW'(cb); cmd_vld = 1'b1;
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic wait_edge(int n);
    while (e < n) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // monitor
  logic [47:0] prev = '0;
  int nrise[48], rpos[48];
  int both_hi, any_hi;
  always @(negedge clk) begin
    if (rst_n && e > 0 && !finished) begin
      automatic int w = e / P;
      if (e % P == 0) begin
        for (int g = 0; g < 48; g++) begin nrise[g] = 0; rpos[g] = -1; end
        both_hi = 0; any_hi = 0;
      end
      for (int g = 0; g < 48; g++)
        if (gate[g] && !prev[g]) begin nrise[g]++; rpos[g] = e % P; end
      if (gate != 0) any_hi++;
      for (int b = 0; b < 24; b++) begin
        automatic int up = (b / 3) * 6 + 2 * (b % 3);
        automatic int dn = (b / 3) * 6 + ((b % 3 == 0) ? 3 : (b % 3 == 1) ? 5 : 1);
        if (gate[up] && gate[dn]) both_hi++;
      end
      if (e % P == P - 1) begin
        vectors++;
        if (both_hi != 0) begin
          miscompares++;
          $display("FAIL R8 window %0d pair overlap samples actual %0d expected 0", w, both_hi);
        end
        if (w == 0) begin
          vectors++;
          if (any_hi != 0) begin
            miscompares++;
            $display("FAIL R1 samples with a gate high before first wrap actual %0d expected 0", any_hi);
          end
        end
        while (q.size() > 0 && q[0].win == w) begin
          automatic exp_t it = q.pop_front();
          vectors++;
          if (nrise[it.g] != 1) begin
            miscompares++;
            $display("FAIL R9 R2 window %0d gate %0d rises actual %0d expected 1", w, it.g, nrise[it.g]);
          end
          vectors++;
          if (rpos[it.g] != it.pos) begin
            miscompares++;
            $display("FAIL R3 R4 R5 R6 R7 R8 window %0d gate %0d rise pos actual %0d expected %0d",
                     w, it.g, rpos[it.g], it.pos);
          end
        end
      end
    end
    prev = gate;
  end

  // driver
  initial begin
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (gate != 0) begin
      miscompares++;
      $display("FAIL R1 gates after reset actual %h expected 0", gate);
    end
    wait_edge(100);
    strobe(16'h1000, 16'hE000);
    push_period(2, 16'h1000, 16'hE000);
    wait_edge(P + 200);
    // R7: inputs change with strobe low
    @(negedge clk);
    cmd_a = 16'h7777; cmd_b = 16'h3333;
    wait_edge(2 * P + 300);
    strobe(16'h4000, 16'h0800);
    wait_edge(2 * P + 5000);
    strobe(16'h2345, 16'h9ABC);
    push_period(4, 16'h2345, 16'h9ABC);
    wait_edge(5 * P + 5);
    finished = 1;
    vectors++;
    if (q.size() != 0) begin
      miscompares++;
      $display("FAIL R9 unchecked items actual %0d expected 0", q.size());
    end
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    finished = 1;
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual %0d expected %0d", e, 5 * P + 5);
    report();
  end
endmodule